// File: doc/BRIEF.md
# Degraded Link Width Selector

This block picks the width and lane group that a multi-lane serial link port runs at after each training attempt. At every training-done strobe it samples three inputs: the native width of the port, a mask of the lanes that passed training and a flag saying the lane wiring is reversed. It then chooses the widest allowed group in which every lane passed. Fallback groups are aligned and come from a fixed set that depends on the native width. A narrower group is only taken when no wider group is usable.

The registered result holds until the next strobe. It gives the active lane count, the base lane of the chosen group, the orientation in use, a degraded flag and the lowest failing lane. Whenever the degraded flag changes value, a one-cycle interrupt request fires so that software can react. When no allowed lane passes, the link is reported down with a width of zero.

Top module: `link_width_sel`

## Requirements
- R1: `native_i` encodes the native width as 0=x2, 1=x4, 2=x8, 3=x16. `width_o` reports the active lane count (0, 1, 2, 4, 8 or 16). All outputs load on the clock edge that samples `train_done_i` high and hold their values while it is low, whatever the other inputs do.
- R2: If every lane below the native width passes, `width_o` is the native width, `base_lane_o` is 0 and `degraded_o` is 0. Lanes at or above the native width are ignored.
- R3: An x8 fallback is allowed only with native x16, on base lane 0 or 8.
- R4: An x4 fallback is allowed only with native x8 or x16, on a base lane that is a multiple of 4 and lies inside the native width.
- R5: An x2 fallback is allowed only with native x4 or wider, on a base lane that is a multiple of 4 and lies inside the native width, and only while `rev_i` is 0. Lanes 2-3 are never an x2 group.
- R6: An x1 fallback uses the lowest-numbered passing lane below the native width.
- R7: A wider candidate always beats a narrower one. Among candidates of the same width, the lowest base lane wins.
- R8: If no lane below the native width passes, the outputs are `width_o`=0, `base_lane_o`=0, `rev_o`=0 and `degraded_o`=0.
- R9: `rev_o` equals the sampled `rev_i` when the chosen width is 2 or more, and is 0 otherwise.
- R10: `degraded_o` is 1 exactly when the chosen width is nonzero and below the native width.
- R11: `fail_lane_o` is the lowest-numbered failing lane below the native width, or 0 if none fails.
- R12: `irq_o` is high for exactly the one cycle after a strobe that changes `degraded_o`, and low at all other times.
- R13: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| native_i | input | 2 | Native width code (0=x2, 1=x4, 2=x8, 3=x16) |
| lane_ok_i | input | 16 | One bit per lane, 1 = lane passed training |
| rev_i | input | 1 | Lane wiring is reversed |
| train_done_i | input | 1 | Training attempt finished; sample inputs |
| width_o | output | 5 | Active lane count, 0 = link down |
| base_lane_o | output | 4 | Lowest lane of the chosen group |
| rev_o | output | 1 | Chosen group runs in reversed orientation |
| degraded_o | output | 1 | Running narrower than native |
| fail_lane_o | output | 4 | Lowest failing lane within native width |
| irq_o | output | 1 | One-cycle pulse on a degraded-flag change |

## Verification
The assertions assume only that the inputs are synchronous to the clock and settled at the edge where `train_done_i` is high. They place no limit on how `lane_ok_i`, `native_i` or `rev_i` move between strobes, and no limit on the strobe rate. The stimulus changes inputs on the falling edge and gives each strobe one cycle. It also moves the lane mask and native code while the strobe is low, which shows that the outputs and the interrupt stay put until the next strobe.

// File: rtl/lws_pkg.sv
package lws_pkg;
  typedef enum logic [1:0] {
    NAT_X2  = 2'd0,
    NAT_X4  = 2'd1,
    NAT_X8  = 2'd2,
    NAT_X16 = 2'd3
  } native_e;

  function automatic int nat_lane_count(native_e code);
    return 2 << int'(code);
  endfunction

  // group stride: x2 groups sit on 4-lane boundaries, wider groups on their own size
  function automatic int group_step(int gw);
    return (gw > 4) ? gw : 4;
  endfunction
endpackage

// File: rtl/lws_lowest.sv
module lws_lowest #(
  parameter int N  = 16,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          hit_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/lws_group_scan.sv
module lws_group_scan #(
  parameter int LANES = 16,
  parameter int GW    = 2,
  parameter int STEP  = 4,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [LANES-1:0] ok_i,
  output logic             hit_o,
  output logic [LW-1:0]    base_o
);
  localparam int NG = LANES / STEP;

  logic [NG-1:0] full;
  logic          unused_ok;

  assign unused_ok = ^ok_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign full[g] = &ok_i[g*STEP +: GW];
  end

  always_comb begin
    hit_o  = |full;
    base_o = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (full[g]) base_o = LW'(g * STEP);
    end
  end
endmodule

// File: rtl/link_width_sel.sv
module link_width_sel #(
  parameter int LANES = 16,
  localparam int LW   = $clog2(LANES),
  localparam int WW   = LW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       native_i,
  input  logic [LANES-1:0] lane_ok_i,
  input  logic             rev_i,
  input  logic             train_done_i,
  output logic [WW-1:0]    width_o,
  output logic [LW-1:0]    base_lane_o,
  output logic             rev_o,
  output logic             degraded_o,
  output logic [LW-1:0]    fail_lane_o,
  output logic             irq_o
);
  import lws_pkg::*;

  logic [WW-1:0]    nat_lanes;
  logic [LANES-1:0] nat_mask;
  logic [LANES-1:0] ok_in;
  logic [LANES-1:0] bad_in;
  logic             all_ok;

  assign nat_lanes = WW'(nat_lane_count(native_e'(native_i)));
  assign nat_mask  = ~({LANES{1'b1}} << nat_lanes);
  assign ok_in     = lane_ok_i & nat_mask;
  assign bad_in    = ~lane_ok_i & nat_mask;
  assign all_ok    = (ok_in == nat_mask);

  // level 0 = x1, level k = group of 2^k lanes
  logic [LW-1:0] lvl_hit;
  logic [LW-1:0] lvl_base [LW];

  lws_lowest #(.N(LANES), .LW(LW)) u_x1 (
    .vec_i (ok_in),
    .hit_o (lvl_hit[0]),
    .idx_o (lvl_base[0])
  );

  for (genvar lv = 1; lv < LW; lv++) begin : g_lvl
    lws_group_scan #(
      .LANES (LANES),
      .GW    (1 << lv),
      .STEP  (group_step(1 << lv)),
      .LW    (LW)
    ) u_scan (
      .ok_i   (ok_in),
      .hit_o  (lvl_hit[lv]),
      .base_o (lvl_base[lv])
    );
  end

  logic          fail_hit;
  logic [LW-1:0] fail_idx;

  lws_lowest #(.N(LANES), .LW(LW)) u_fail (
    .vec_i (bad_in),
    .hit_o (fail_hit),
    .idx_o (fail_idx)
  );

  logic [WW-1:0] sel_w;
  logic [LW-1:0] sel_b;
  logic          sel_deg;
  logic          sel_rev;

  always_comb begin
    sel_w = '0;
    sel_b = '0;
    // ascending scan: the widest allowed level overwrites narrower ones
    for (int lv = 0; lv < LW; lv++) begin
      if (lvl_hit[lv] && ((WW'(1) << lv) < nat_lanes) && !(lv == 1 && rev_i)) begin
        sel_w = WW'(1) << lv;
        sel_b = lvl_base[lv];
      end
    end
    if (all_ok) begin
      sel_w = nat_lanes;
      sel_b = '0;
    end
    sel_deg = (sel_w != '0) && !all_ok;
    sel_rev = rev_i && (sel_w > WW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o     <= '0;
      base_lane_o <= '0;
      rev_o       <= 1'b0;
      degraded_o  <= 1'b0;
      fail_lane_o <= '0;
      irq_o       <= 1'b0;
    end else if (train_done_i) begin
      width_o     <= sel_w;
      base_lane_o <= sel_b;
      rev_o       <= sel_rev;
      degraded_o  <= sel_deg;
      fail_lane_o <= fail_hit ? fail_idx : '0;
      irq_o       <= (sel_deg != degraded_o);
    end else begin
      irq_o       <= 1'b0;
    end
  end
endmodule

// File: rtl/lws_chk.sv
module lws_chk #(
  parameter int LANES = 16,
  localparam int LW   = $clog2(LANES),
  localparam int WW   = LW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          train_done_i,
  input logic [WW-1:0] width_o,
  input logic [LW-1:0] base_lane_o,
  input logic          rev_o,
  input logic          degraded_o,
  input logic [LW-1:0] fail_lane_o,
  input logic          irq_o
);
  // R1: outputs frozen without a strobe
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !train_done_i |=> ($stable(width_o) && $stable(base_lane_o) && $stable(rev_o)
                       && $stable(degraded_o) && $stable(fail_lane_o)));

  // R1: width is a power-of-two lane count or zero
  a_r1_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(width_o) <= 1);

  // R4/R3: groups of 4 or more sit on their own size boundary
  a_r4_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_o >= WW'(4)) |-> (({1'b0, base_lane_o} & (width_o - WW'(1))) == '0));

  // R5: x2 groups sit on 4-lane boundaries
  a_r5_x2_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_o == WW'(2)) |-> (base_lane_o[1:0] == 2'b00));

  // R5: a degraded x2 never runs reversed
  a_r5_x2_no_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (degraded_o && width_o == WW'(2)) |-> !rev_o);

  // R9: no orientation on x1 or link down
  a_r9_rev_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_o |-> (width_o > WW'(1)));

  // R8/R10: degraded implies a live link narrower than the maximum
  a_r10_deg_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    degraded_o |-> (width_o != '0 && width_o < WW'(LANES)));

  // R12: pulse only after a strobe, and only with a flag change
  a_r12_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(train_done_i) && degraded_o != $past(degraded_o)));

  a_r12_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !train_done_i) |=> !irq_o);
endmodule

bind link_width_sel lws_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/link_width_sel_tb.sv
module link_width_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  native_i = '0;
  logic [15:0] lane_ok_i = '0;
  logic        rev_i = 1'b0;
  logic        train_done_i = 1'b0;
  logic [4:0]  width_o;
  logic [3:0]  base_lane_o;
  logic        rev_o;
  logic        degraded_o;
  logic [3:0]  fail_lane_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  logic prev_deg = 1'b0;

  always #4 clk_i = ~clk_i;

  link_width_sel u_dut (.*);

  // {native[1:0], mask[15:0], rev, width[4:0], base[3:0], rev_o, deg, fail[3:0]}
  localparam int NV = 20;
  localparam logic [33:0] VEC [NV] = '{
    {2'd3, 16'hFFFF, 1'b0, 5'd16, 4'd0,  1'b0, 1'b0, 4'd0 },  // R2 full x16
    {2'd3, 16'hFFFF, 1'b1, 5'd16, 4'd0,  1'b1, 1'b0, 4'd0 },  // R9 reversed full
    {2'd3, 16'hFFF7, 1'b0, 5'd8,  4'd8,  1'b0, 1'b1, 4'd3 },  // R3 x8 upper
    {2'd3, 16'hEFFF, 1'b0, 5'd8,  4'd0,  1'b0, 1'b1, 4'd12},  // R7 lowest base
    {2'd3, 16'hFEFE, 1'b0, 5'd4,  4'd4,  1'b0, 1'b1, 4'd0 },  // R4 x4 base 4
    {2'd3, 16'h3030, 1'b0, 5'd2,  4'd4,  1'b0, 1'b1, 4'd0 },  // R5 x2 base 4
    {2'd3, 16'h3030, 1'b1, 5'd1,  4'd4,  1'b0, 1'b1, 4'd0 },  // R5 reversed x2 -> R6 x1
    {2'd3, 16'h0000, 1'b0, 5'd0,  4'd0,  1'b0, 1'b0, 4'd0 },  // R8 down
    {2'd2, 16'hFF01, 1'b0, 5'd1,  4'd0,  1'b0, 1'b1, 4'd1 },  // R11 upper lanes ignored
    {2'd2, 16'h00FF, 1'b0, 5'd8,  4'd0,  1'b0, 1'b0, 4'd0 },  // R2 native x8
    {2'd2, 16'h00EF, 1'b0, 5'd4,  4'd0,  1'b0, 1'b1, 4'd4 },  // R4 x4 in x8
    {2'd2, 16'h00CC, 1'b0, 5'd1,  4'd2,  1'b0, 1'b1, 4'd0 },  // R5 lanes 2-3 not a group
    {2'd1, 16'h000B, 1'b0, 5'd2,  4'd0,  1'b0, 1'b1, 4'd2 },  // R5 x2 in x4
    {2'd1, 16'h000B, 1'b1, 5'd1,  4'd0,  1'b0, 1'b1, 4'd2 },  // R6 reversed x4 -> x1
    {2'd1, 16'h000F, 1'b1, 5'd4,  4'd0,  1'b1, 1'b0, 4'd0 },  // R9 reversed x4 full
    {2'd0, 16'h0002, 1'b0, 5'd1,  4'd1,  1'b0, 1'b1, 4'd0 },  // R6 x2 native -> lane 1
    {2'd0, 16'h0003, 1'b1, 5'd2,  4'd0,  1'b1, 1'b0, 4'd0 },  // R9 reversed x2 native
    {2'd0, 16'hFFFC, 1'b0, 5'd0,  4'd0,  1'b0, 1'b0, 4'd0 },  // R8 down, upper ignored
    {2'd3, 16'h8000, 1'b0, 5'd1,  4'd15, 1'b0, 1'b1, 4'd0 },  // R6 x1 top lane
    {2'd3, 16'h7FFF, 1'b0, 5'd8,  4'd0,  1'b0, 1'b1, 4'd15}   // R7 x8 wins over x1
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk_zero(input string tag);
    chk(width_o == 0 && base_lane_o == 0 && !rev_o && !degraded_o
        && fail_lane_o == 0 && !irq_o, {tag, " outputs zero"},
        int'({width_o, base_lane_o, rev_o, degraded_o, fail_lane_o, irq_o}), 0);
  endtask

  task automatic run_vec(input int i, input logic [33:0] v);
    logic exp_irq;
    @(negedge clk_i);
    native_i = v[33:32]; lane_ok_i = v[31:16]; rev_i = v[15];
    train_done_i = 1'b1;
    @(negedge clk_i);
    train_done_i = 1'b0;
    exp_irq = (v[4] != prev_deg);
    prev_deg = v[4];
    chk(width_o == v[14:10], $sformatf("R7 vec%0d width", i), width_o, v[14:10]);
    chk(base_lane_o == v[9:6], $sformatf("R7 vec%0d base", i), base_lane_o, v[9:6]);
    chk(rev_o == v[5], $sformatf("R9 vec%0d rev", i), rev_o, v[5]);
    chk(degraded_o == v[4], $sformatf("R10 vec%0d degraded", i), degraded_o, v[4]);
    chk(fail_lane_o == v[3:0], $sformatf("R11 vec%0d fail lane", i), fail_lane_o, v[3:0]);
    chk(irq_o == exp_irq, $sformatf("R12 vec%0d irq", i), irq_o, exp_irq);
    if (exp_irq) begin
      @(negedge clk_i);
      chk(!irq_o, $sformatf("R12 vec%0d irq one cycle", i), irq_o, 0);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_zero("R13 reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

    // R1: inputs move without a strobe, outputs hold
    @(negedge clk_i);
    native_i = 2'd0; lane_ok_i = 16'h0000; rev_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(width_o == 5'd8 && base_lane_o == 0 && fail_lane_o == 4'd15 && degraded_o && !irq_o,
        "R1 hold without strobe", width_o, 8);

    // R13: reset mid-run clears a degraded state
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_zero("R13 mid-run reset");
    rst_ni = 1'b1;
    prev_deg = 1'b0;

    // R3/R12: first degrade after reset pulses the interrupt
    run_vec(100, {2'd3, 16'hFFFE, 1'b0, 5'd8, 4'd8, 1'b0, 1'b1, 4'd0});
    // R12: same degraded state again, no pulse
    run_vec(101, {2'd3, 16'hF0FF, 1'b1, 5'd8, 4'd0, 1'b1, 1'b1, 4'd8});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule